// File: doc/BRIEF.md
# Bit-Set/Reset Output Port Controller

This block holds an 8-bit general-purpose output port that software can never write directly. Port bits change only through two write-only command offsets. A write to the set offset turns on every port bit whose data-bus bit is one. A write to the clear offset turns off every port bit whose data-bus bit is one. Data-bus zeros leave the matching port bits as they are, so one driver can own a bit without a read-modify-write sequence. Three of the port bits (3, 1 and 0) reach pins, and each is inverted on the way out. Pins therefore sit high while their bits are zero.

The same decoder treats reads at two further offsets as strobes for a small 16-bit down-counter/timer. A start read loads the counter from a preload value and sets it running. At terminal count the counter raises a ready flag and reloads. In counter mode it also drives a sticky output that can replace port bit 3 at its pin. A stop read halts the counter and clears both the ready flag and that output. Every read returns zero.

Top module: `bsr_port_ctl`

## Requirements
- R1: After a synchronous active-low reset, the port register is zero, `pin_out` is 3'b111 and `ctr_ready` is 0.
- R2: A write strobe at offset 0x1 sets every port bit whose `bus_wdata` bit is 1, from the next clock edge on, and leaves bits written as 0 unchanged.
- R3: A write strobe at offset 0x3 clears every port bit whose `bus_wdata` bit is 1, from the next clock edge on, and leaves bits written as 0 unchanged.
- R4: `pin_out[0]` is the inverse of port bit 0 and `pin_out[1]` is the inverse of port bit 1. `pin_out[2]` is the inverse of the selected bit-3 source.
- R5: Port bits 7, 6, 5, 4 and 2 have no effect on any pin.
- R6: The port register changes only on a write strobe at offset 0x1 or 0x3. Reads at those offsets and writes at any other offset leave it unchanged.
- R7: A read strobe at offset 0x2 loads the counter with `ctr_preload` and starts it. `ctr_ready` rises exactly `ctr_preload`+1 clock edges after the start edge.
- R8: With `ctr_mode`=1 (counter mode), `pin_out[2]` shows the inverted counter output and port bit 3 has no effect on it. The counter output goes high at terminal count and stays high until a stop read.
- R9: A read strobe at offset 0x0 stops the counter and clears both `ctr_ready` and the counter output. No further ready occurs until the next start.
- R10: With `ctr_mode`=0 (timer mode), terminal count still sets `ctr_ready`, but `pin_out[2]` follows port bit 3 and not the counter.
- R11: `bus_rdata` is zero for every read, including the start and stop reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data, used as a bit mask |
| bus_rdata | output | 8 | Read data, always zero |
| ctr_mode | input | 1 | 1 = counter output drives bit-3 pin, 0 = port bit 3 drives it |
| ctr_preload | input | 16 | Counter reload value |
| ctr_ready | output | 1 | Counter/timer ready flag |
| pin_out | output | 3 | Inverted pins for bit 3, bit 1 and bit 0 (index 2, 1, 0) |

## Verification
The hardest condition to reach from the ports is the counter-mode state where the sticky counter output and a set port bit 3 compete for the same pin. To reach it, the stimulus first sets bit 3 through the set offset and then switches to counter mode with a short preload. It then shows that the pin stays high before terminal count, drops at exactly the predicted edge, holds low across later reloads and rises again only after the stop read. Reads at the set offset and writes to unused offsets are sent between known states to show that the port does not move.

// File: rtl/bsr_port_pkg.sv
// Package: shared widths, command bundle and bit-3 source type for the
// bit-set/reset output port controller.
package bsr_port_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 16;
    localparam int OP3_IDX = 3;

    // One-cycle command strobes produced by the bus decoder
    typedef struct packed {
        logic set_bits;
        logic clr_bits;
        logic ctr_start;
        logic ctr_stop;
    } cmd_t;

    // Source selected for the bit-3 pin
    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_CTR = 1'b1
    } op3_src_e;
endpackage

// File: rtl/bsr_cmd_decode.sv
// Module: bsr_cmd_decode
// Turns single-cycle bus strobes at four offsets into command pulses.
// Assumes the bus presents at most one access per cycle. The read data is
// meaningless, so it is tied to zero.
module bsr_cmd_decode
    import bsr_port_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] SET_OFF   = 4'h1,
    parameter logic [ADDR_W-1:0] CLR_OFF   = 4'h3,
    parameter logic [ADDR_W-1:0] START_OFF = 4'h2,
    parameter logic [ADDR_W-1:0] STOP_OFF  = 4'h0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output cmd_t              cmd,
    output logic [DATA_W-1:0] rdata
);
    // Address compare: writes drive the port commands, reads drive the counter commands
    always_comb begin
        cmd.set_bits  = wr && (addr == SET_OFF);
        cmd.clr_bits  = wr && (addr == CLR_OFF);
        cmd.ctr_start = rd && (addr == START_OFF);
        cmd.ctr_stop  = rd && (addr == STOP_OFF);
    end

    // Reads carry no information
    assign rdata = '0;
endmodule

// File: rtl/bsr_port_reg.sv
// Module: bsr_port_reg
// Port register changed only by mask-driven set and clear commands.
// Assumes set and clear never arrive in the same cycle; if they do, the
// clear wins.
module bsr_port_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_bits,
    input  logic              clr_bits,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] port_q
);
    // Apply the mask-based set or clear, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            port_q <= '0;
        else if (clr_bits)
            port_q <= port_q & ~mask;
        else if (set_bits)
            port_q <= port_q | mask;
    end

    // R2: every masked bit is one after a set command
    a_r2_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits && !clr_bits) |=> ((port_q & $past(mask)) == $past(mask)));
    // R3: every masked bit is zero after a clear command
    a_r3_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bits |=> ((port_q & $past(mask)) == '0));
    // R6: without a command the register holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_bits && !clr_bits) |=> $stable(port_q));
endmodule

// File: rtl/bsr_down_timer.sv
// Module: bsr_down_timer
// Reloading down-counter with a ready flag and a sticky counter-mode output.
// A start strobe loads the preload value, and terminal count (zero) sets ready
// and reloads. A stop strobe halts the counter and clears ready and the output.
module bsr_down_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             ctr_mode,
    input  logic [CNT_W-1:0] preload,
    output logic             ready,
    output logic             ctr_out
);
    logic [CNT_W-1:0] count;
    logic             running;

    // Counter state machine: stop > start > count/terminal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
            ready   <= 1'b0;
            ctr_out <= 1'b0;
        end else if (stop) begin
            running <= 1'b0;
            ready   <= 1'b0;
            ctr_out <= 1'b0;
        end else if (start) begin
            count   <= preload;
            running <= 1'b1;
        end else if (running) begin
            if (count == '0) begin
                count <= preload;
                ready <= 1'b1;
                if (ctr_mode)
                    ctr_out <= 1'b1;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    // R7: start loads the preload value and runs
    a_r7_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> (running && (count == $past(preload))));
    // R9: stop clears ready, output and running
    a_r9_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!ready && !ctr_out && !running));
    // R8: the counter output is sticky until stop
    a_r8_out_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_out && !stop) |=> ctr_out);
    // R9: a halted counter produces no new ready or output
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start && !stop) |=> ($stable(ready) && $stable(ctr_out)));
endmodule

// File: rtl/bsr_port_ctl.sv
// Module: bsr_port_ctl (top)
// Bit-set/reset output port with a companion down-counter. Bits 3, 1 and 0
// are pinned out inverted. The bit-3 pin can be taken over by the counter
// output in counter mode. Assumes a single-cycle bus with one access per cycle.
module bsr_port_ctl
    import bsr_port_pkg::*;
#(
    parameter int ADDR_W = bsr_port_pkg::ADDR_W,
    parameter int DATA_W = bsr_port_pkg::DATA_W,
    parameter int CNT_W  = bsr_port_pkg::CNT_W,
    parameter logic [ADDR_W-1:0] SET_OFF   = 4'h1,
    parameter logic [ADDR_W-1:0] CLR_OFF   = 4'h3,
    parameter logic [ADDR_W-1:0] START_OFF = 4'h2,
    parameter logic [ADDR_W-1:0] STOP_OFF  = 4'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ctr_mode,
    input  logic [CNT_W-1:0]  ctr_preload,
    output logic              ctr_ready,
    output logic [2:0]        pin_out
);
    cmd_t              cmd;
    logic [DATA_W-1:0] port_q;
    logic              ctr_out;
    op3_src_e          op3_src;
    logic              op3_val;
    logic              unused_bits;

    bsr_cmd_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SET_OFF(SET_OFF), .CLR_OFF(CLR_OFF),
        .START_OFF(START_OFF), .STOP_OFF(STOP_OFF)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .cmd(cmd), .rdata(bus_rdata)
    );

    bsr_port_reg #(.DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .set_bits(cmd.set_bits), .clr_bits(cmd.clr_bits),
        .mask(bus_wdata), .port_q(port_q)
    );

    bsr_down_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .start(cmd.ctr_start), .stop(cmd.ctr_stop),
        .ctr_mode(ctr_mode), .preload(ctr_preload),
        .ready(ctr_ready), .ctr_out(ctr_out)
    );

    // Bit-3 pin source select
    always_comb begin
        op3_src = ctr_mode ? SRC_CTR : SRC_REG;
        op3_val = (op3_src == SRC_CTR) ? ctr_out : port_q[OP3_IDX];
    end

    // Pin inversion for the three pinned bits
    assign pin_out = ~{op3_val, port_q[1], port_q[0]};

    // Stored but unpinned bits
    assign unused_bits = ^{port_q[DATA_W-1:OP3_IDX+1], port_q[2]};
endmodule

// File: tb/bsr_port_ctl_test.sv
module bsr_port_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        ctr_mode;
    logic [15:0] ctr_preload;
    logic        ctr_ready;
    logic [2:0]  pin_out;
    int          n_chk = 0;
    int          n_err = 0;

    localparam logic [3:0] A_STOP = 4'h0, A_SET = 4'h1, A_START = 4'h2, A_CLR = 4'h3;

    // {is_clear, data, expected pin_out}, walked from a zero port in timer mode
    localparam int NV = 10;
    localparam logic [11:0] VECS [NV] = '{
        {1'b0, 8'h01, 3'b110},
        {1'b0, 8'h08, 3'b010},
        {1'b0, 8'hF4, 3'b010},
        {1'b0, 8'h02, 3'b000},
        {1'b1, 8'h00, 3'b000},
        {1'b1, 8'hF6, 3'b010},
        {1'b1, 8'h08, 3'b110},
        {1'b0, 8'h0A, 3'b000},
        {1'b1, 8'h01, 3'b001},
        {1'b1, 8'hFF, 3'b111}
    };

    always #10 clk = ~clk;

    bsr_port_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctr_mode(ctr_mode), .ctr_preload(ctr_preload),
        .ctr_ready(ctr_ready), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic bus_read(input logic [3:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk(req, {8'h00, bus_rdata}, 16'h0000);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = 4'h0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = 8'h00; ctr_mode = 1'b0; ctr_preload = 16'd0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1 pins", {13'd0, pin_out}, 16'h0007);
        chk("R1 ready", {15'd0, ctr_ready}, 16'h0000);

        // R2/R3/R4/R5 vector walk
        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i][11] ? A_CLR : A_SET, VECS[i][10:3]);
            chk(VECS[i][11] ? "R3/R4/R5 clear vector" : "R2/R4/R5 set vector",
                {13'd0, pin_out}, {13'd0, VECS[i][2:0]});
        end

        // R6: writes elsewhere and reads at command offsets leave the port
        bus_write(A_SET, 8'h0B);
        chk("R2 set all pinned", {13'd0, pin_out}, 16'h0000);
        bus_write(4'h7, 8'hFF);
        chk("R6 write unused offset", {13'd0, pin_out}, 16'h0000);
        bus_write(A_START, 8'hFF);
        chk("R6 write start offset", {13'd0, pin_out}, 16'h0000);
        bus_read(A_CLR, "R11 read clear offset");
        chk("R6 read clear offset", {13'd0, pin_out}, 16'h0000);
        bus_write(A_CLR, 8'hFF);
        bus_read(A_SET, "R11 read set offset");
        chk("R6 read set offset", {13'd0, pin_out}, 16'h0007);

        // R7/R10: timer mode, preload 5
        ctr_preload = 16'd5;
        bus_read(A_START, "R11 start read");
        wait_cyc(5);
        chk("R7 not ready yet", {15'd0, ctr_ready}, 16'h0000);
        wait_cyc(1);
        chk("R7 ready at preload+1", {15'd0, ctr_ready}, 16'h0001);
        chk("R10 pin3 follows register", {13'd0, pin_out}, 16'h0007);
        bus_write(A_SET, 8'h08);
        chk("R10 pin3 set bit", {13'd0, pin_out}, 16'h0003);
        bus_read(A_STOP, "R11 stop read");
        chk("R9 stop clears ready", {15'd0, ctr_ready}, 16'h0000);
        wait_cyc(20);
        chk("R9 halted no ready", {15'd0, ctr_ready}, 16'h0000);

        // R8: counter mode with port bit 3 set
        ctr_mode = 1'b1; ctr_preload = 16'd3;
        wait_cyc(1);
        chk("R8 port bit3 masked", {13'd0, pin_out}, 16'h0007);
        bus_read(A_START, "R11 start read 2");
        wait_cyc(3);
        chk("R8 output before terminal", {13'd0, pin_out}, 16'h0007);
        wait_cyc(1);
        chk("R8 output at terminal", {13'd0, pin_out}, 16'h0003);
        chk("R7 ready counter mode", {15'd0, ctr_ready}, 16'h0001);
        wait_cyc(10);
        chk("R8 output sticky", {13'd0, pin_out}, 16'h0003);
        bus_read(A_STOP, "R11 stop read 2");
        chk("R9 stop clears output", {13'd0, pin_out}, 16'h0007);
        chk("R9 stop clears ready 2", {15'd0, ctr_ready}, 16'h0000);
        ctr_mode = 1'b0;
        wait_cyc(1);
        chk("R4 pin3 back to register", {13'd0, pin_out}, 16'h0003);

        // R1: reset in mid-operation
        bus_write(A_SET, 8'h03);
        rst_n = 1'b0;
        wait_cyc(1);
        rst_n = 1'b1;
        chk("R1 reset clears port", {13'd0, pin_out}, 16'h0007);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule